// File: doc/BRIEF.md
# Four-Activate Rolling Window Limiter

This block guards the rule that a DRAM device may see no more than four row activates inside any rolling window of a programmed number of cycles. It remembers how long ago each of the last four activates happened. From that history it raises a permission output whenever a new activate would keep every window of the programmed length at four activates or fewer. The command scheduler of a DRAM controller samples the permission before it issues an activate. It pulses the activate strobe in the cycle the command goes out.

The window length is a 6-bit count of controller clock cycles. A configuration input tells whether the device has eight or more banks. The rule only matters on such devices. For a four-bank part the block acts as if the window were one cycle long, so it never blocks. An activate issued while permission is low raises a sticky violation flag, and it is still entered into the history. Only reset clears the flag.

Top module: `faw_act_limiter`

## Requirements
- R1: After reset the history is empty, `act_ok_o` is 1 and `viol_o` is 0.
- R2: While fewer than four activates are held in the history, `act_ok_o` is 1 whatever the window length.
- R3: With `eight_bank_i` = 1 and four activates recorded, `act_ok_o` is 1 in cycle N only if the oldest of those four was strobed at cycle N - `win_i` or earlier. So no run of `win_i` consecutive cycles contains more than four activates.
- R4: `act_ok_o` follows `win_i` and `eight_bank_i` in the same cycle, with no register delay.
- R5: With `eight_bank_i` = 0, `act_ok_o` is 1 in every cycle, including back-to-back activates.
- R6: A window length of 0 or 1 never blocks an activate, even with `eight_bank_i` = 1.
- R7: Each recorded age saturates at 63 cycles (2^6-1) and never wraps. After a long idle time an activate is allowed even with the largest window of 63.
- R8: `act_i` = 1 in a cycle where `act_ok_o` = 0 sets `viol_o` from the next cycle on. `viol_o` stays 1 until reset and is never set by allowed activates.
- R9: An activate strobed while blocked is still recorded, so later permission is measured from it as from any other activate.
- R10: A cycle with `act_i` = 0 adds nothing to the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| act_i | input | 1 | Activate issued this cycle |
| win_i | input | 6 | Rolling window length in cycles |
| eight_bank_i | input | 1 | 1: device has eight or more banks, window enforced |
| act_ok_o | output | 1 | An activate is permitted this cycle |
| viol_o | output | 1 | Sticky flag: an activate was issued while not permitted |

## Verification
The bench builds the block with its default parameters: a 6-bit window and a four-deep history. With these the full window range 0 to 63 can be driven, and the age saturation point is reached after a short idle stretch. The edge cycles on either side of the window boundary can be checked, as well as the moment the fifth activate becomes legal. A reference model of strobe times in the bench predicts the permission in every cycle. Scenarios cover a blocked strobe entering the history, a window change while the history is full, and a switch between bank configurations.

// File: rtl/faw_pkg.sv
package faw_pkg;
   // default sizing for the activate window limiter
   localparam int unsigned FAW_WIN_W_DEF = 6;
   localparam int unsigned FAW_DEPTH_DEF = 4;
   // 1: window enforced only on multi-bank devices, 0: always enforced
   localparam bit          FAW_BANK_GATE_DEF = 1'b1;
endpackage : faw_pkg

// File: rtl/faw_hist_slot.sv
module faw_hist_slot #(
   parameter int unsigned AGE_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             shift_i,
   input  logic             prev_valid_i,
   input  logic [AGE_W-1:0] prev_age_i,
   output logic             valid_o,
   output logic [AGE_W-1:0] age_o
);
   localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

   logic             valid_q;
   logic [AGE_W-1:0] age_q;
   logic [AGE_W-1:0] age_src;
   logic [AGE_W-1:0] age_nxt;

   always_comb begin
      age_src = shift_i ? prev_age_i : age_q;
      age_nxt = (age_src == AGE_MAX) ? AGE_MAX : age_src + AGE_W'(1);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_q <= 1'b0;
         age_q   <= '0;
      end else begin
         if (shift_i) valid_q <= prev_valid_i;
         age_q <= age_nxt;
      end
   end

   assign valid_o = valid_q;
   assign age_o   = age_q;

   // R7
   age_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_q && !shift_i) |=> (age_q >= $past(age_q)));
endmodule : faw_hist_slot

// File: rtl/faw_win_check.sv
module faw_win_check #(
   parameter int unsigned AGE_W     = 6,
   parameter bit          BANK_GATE = 1'b1
) (
   input  logic             oldest_valid_i,
   input  logic [AGE_W-1:0] oldest_age_i,
   input  logic [AGE_W-1:0] win_i,
   input  logic             multi_bank_i,
   output logic             ok_o
);
   logic [AGE_W-1:0] eff_win;

   generate
      if (BANK_GATE) begin : g_gated
         // few-bank devices collapse to a one-cycle window
         assign eff_win = multi_bank_i ? win_i : AGE_W'(1);
      end else begin : g_always
         assign eff_win = win_i;
      end
   endgenerate

   assign ok_o = !oldest_valid_i || (oldest_age_i >= eff_win);
endmodule : faw_win_check

// File: rtl/faw_act_limiter.sv
module faw_act_limiter
   import faw_pkg::*;
#(
   parameter int unsigned WIN_W     = FAW_WIN_W_DEF,
   parameter int unsigned DEPTH     = FAW_DEPTH_DEF,
   parameter bit          BANK_GATE = FAW_BANK_GATE_DEF
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             act_i,
   input  logic [WIN_W-1:0] win_i,
   input  logic             eight_bank_i,
   output logic             act_ok_o,
   output logic             viol_o
);
   localparam int unsigned AGE_W  = WIN_W;
   localparam int unsigned OLDEST = DEPTH - 1;

   generate
      if (WIN_W < 2)  begin : g_bad_w  $error("WIN_W must be at least 2");  end
      if (DEPTH < 1)  begin : g_bad_d  $error("DEPTH must be at least 1");  end
   endgenerate

   logic [DEPTH-1:0] hist_valid;
   logic [AGE_W-1:0] hist_age [DEPTH];
   logic             ok_w;
   logic             viol_q;

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         logic             pv;
         logic [AGE_W-1:0] pa;
         if (g == 0) begin : g_head
            assign pv = 1'b1;
            assign pa = '0;
         end else begin : g_tail
            assign pv = hist_valid[g-1];
            assign pa = hist_age[g-1];
         end
         faw_hist_slot #(.AGE_W(AGE_W)) slot_i (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .shift_i     (act_i),
            .prev_valid_i(pv),
            .prev_age_i  (pa),
            .valid_o     (hist_valid[g]),
            .age_o       (hist_age[g])
         );
      end
   endgenerate

   faw_win_check #(.AGE_W(AGE_W), .BANK_GATE(BANK_GATE)) chk_i (
      .oldest_valid_i(hist_valid[OLDEST]),
      .oldest_age_i  (hist_age[OLDEST]),
      .win_i         (win_i),
      .multi_bank_i  (eight_bank_i),
      .ok_o          (ok_w)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                viol_q <= 1'b0;
      else if (act_i && !ok_w)    viol_q <= 1'b1;
   end

   assign act_ok_o = ok_w;
   assign viol_o   = viol_q;

   // R2
   partial_hist_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($countones(hist_valid) < DEPTH) |-> act_ok_o);
   // R5
   few_bank_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!eight_bank_i && BANK_GATE) |-> act_ok_o);
   // R8
   viol_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_i && !act_ok_o) |=> viol_o);
   // R8
   viol_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      viol_o |=> viol_o);
   // R9
   blocked_recorded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_i |=> (hist_valid[0] && hist_age[0] == AGE_W'(1)));
   // R10
   idle_no_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !act_i |=> $stable(hist_valid));
endmodule : faw_act_limiter

// File: tb/faw_act_limiter_tb.sv
module faw_act_limiter_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       act = 1'b0;
   logic [5:0] win = 6'd16;
   logic       eight = 1'b1;
   logic       act_ok;
   logic       viol;

   int unsigned n_chk = 0;
   int unsigned n_fail = 0;
   longint      cyc = 0;

   // reference model: strobe times of the last four activates
   longint hist_t [4];
   int     hist_n = 0;
   bit     exp_viol = 1'b0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   faw_act_limiter dut_i (
      .clk_i(clk), .rst_ni(rst_n), .act_i(act), .win_i(win),
      .eight_bank_i(eight), .act_ok_o(act_ok), .viol_o(viol)
   );

   task automatic check(input string req, input logic got, input logic exp, input string what);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%b expected=%b at cycle %0d", req, what, got, exp, cyc);
      end
   endtask

   function automatic bit model_ok(longint now);
      longint age;
      if (!eight || hist_n < 4) return 1'b1;
      age = now - hist_t[3];
      if (age > 63) age = 63;
      return age >= longint'(win);
   endfunction

   task automatic step(input string req, input logic a);
      longint now;
      bit     e;
      @(negedge clk);
      act = a;
      #1;
      now = cyc;
      e = model_ok(now);
      check(req, act_ok, e, "act_ok");
      check(req, viol, exp_viol, "viol");
      @(posedge clk);
      if (a) begin
         if (!e) exp_viol = 1'b1;
         for (int i = 3; i > 0; i--) hist_t[i] = hist_t[i-1];
         hist_t[0] = now;
         if (hist_n < 4) hist_n++;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      act = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      hist_n = 0;
      exp_viol = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      #1;
      check("R1", act_ok, 1'b1, "act_ok after reset");
      check("R1", viol, 1'b0, "viol after reset");
   endtask

   task automatic t_window();
      do_reset();
      eight = 1'b1; win = 6'd16;
      for (int i = 0; i < 4; i++) step("R2", 1'b1);
      for (int i = 0; i < 14; i++) step("R3", 1'b0);
      check("R3", act_ok, 1'b1, "open at window edge");
      step("R3", 1'b1);
      step("R3", 1'b0);
      check("R8", viol, 1'b0, "no viol on legal traffic");
   endtask

   task automatic t_violation();
      do_reset();
      eight = 1'b1; win = 6'd20;
      for (int i = 0; i < 4; i++) step("R2", 1'b1);
      step("R8", 1'b0);
      check("R8", act_ok, 1'b0, "blocked before strobe");
      step("R8", 1'b1);
      step("R8", 1'b0);
      check("R8", viol, 1'b1, "viol set");
      for (int i = 0; i < 30; i++) step("R9", 1'b0);
      step("R9", 1'b1);
      check("R8", viol, 1'b1, "viol still held");
   endtask

   task automatic t_few_bank();
      do_reset();
      eight = 1'b0; win = 6'd16;
      for (int i = 0; i < 10; i++) step("R5", 1'b1);
      check("R5", viol, 1'b0, "no viol with four banks");
   endtask

   task automatic t_small_win();
      do_reset();
      eight = 1'b1; win = 6'd1;
      for (int i = 0; i < 8; i++) step("R6", 1'b1);
      win = 6'd0;
      for (int i = 0; i < 8; i++) step("R6", 1'b1);
      step("R6", 1'b0);
   endtask

   task automatic t_live_win();
      do_reset();
      eight = 1'b1; win = 6'd40;
      for (int i = 0; i < 4; i++) step("R2", 1'b1);
      for (int i = 0; i < 3; i++) step("R10", 1'b0);
      @(negedge clk); win = 6'd5; #1;
      check("R4", act_ok, 1'b1, "short window opens at once");
      win = 6'd40; #1;
      check("R4", act_ok, 1'b0, "long window closes at once");
      eight = 1'b0; #1;
      check("R4", act_ok, 1'b1, "bank flag opens at once");
      eight = 1'b1;
      step("R4", 1'b0);
   endtask

   task automatic t_saturate();
      do_reset();
      eight = 1'b1; win = 6'd63;
      for (int i = 0; i < 4; i++) step("R2", 1'b1);
      for (int i = 0; i < 100; i++) step("R7", 1'b0);
      step("R7", 1'b1);
      for (int i = 0; i < 3; i++) step("R7", 1'b1);
      step("R7", 1'b0);
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_window();
      t_violation();
      t_few_bank();
      t_small_win();
      t_live_win();
      t_saturate();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule : faw_act_limiter_tb_top